// File: doc/BRIEF.md
# Two-Variant L2 Bucket Hash Generator

This block maps a forwarding key, a 12-bit VLAN or forwarding identifier plus a 48-bit MAC address, to two bucket numbers in a layer-2 forwarding table. The default table holds 16384 entries in 4-way buckets, which gives 4096 buckets split into two halves of 2048. The key is first packed into a 60-bit seed. Two XOR-fold hashes of that seed are then formed: a plain fold, and a fold in which two of the 11-bit chunks are rotated before they are combined.

Each table half picks one of the two hashes through its own select bit, so the halves can use the same algorithm or different ones. The half-1 result is moved into the upper half of the bucket space. A lookup engine uses the two bucket numbers to probe both halves for a candidate slot.

The result is captured in a register on a one-cycle input strobe and is presented together with a valid flag.

Top module: `l2_bucket_hasher`

## Requirements
- R1: The seed is `{vlan_id, mac_addr}`, 60 bits wide, with `vlan_id` in seed bits 59:48 and `mac_addr` in seed bits 47:0.
- R2: The plain hash is an 11-bit value. It is the XOR of seed slices 10:0, 21:11, 32:22, 43:33 and 54:44, together with seed bits 59:55 zero-extended to 11 bits.
- R3: The rotated hash is built the same way as the plain hash, with two changes: slice 21:11 is rotated left by 6 within 11 bits, and slice 43:33 is rotated left by 5 within 11 bits, before the XOR. Seed bits 59:55 take part unchanged.
- R4: `alg_sel[0]` chooses the half-0 result. A value of 0 gives the plain hash and 1 gives the rotated hash. `bucket_lo` equals the chosen hash.
- R5: `alg_sel[1]` chooses the half-1 hash with the same encoding, independently of `alg_sel[0]`. `bucket_hi` equals the chosen hash plus 2048.
- R6: Whenever `out_valid` is high, `bucket_lo` lies in 0..2047 (bit 11 is 0) and `bucket_hi` lies in 2048..4095 (bit 11 is 1).
- R7: When `in_valid` is high on a rising clock edge, `out_valid` is high after that edge and the buckets show the result for the inputs sampled at that edge. When `in_valid` is low on an edge, `out_valid` is low after it.
- R8: While `in_valid` is low, changes on `mac_addr`, `vlan_id` and `alg_sel` have no effect: both bucket outputs keep their last values.
- R9: While `rst_n` is low, `out_valid`, `bucket_lo` and `bucket_hi` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures the key and the algorithm selects |
| mac_addr | input | 48 | MAC address part of the key |
| vlan_id | input | 12 | VLAN or forwarding identifier part of the key |
| alg_sel | input | 2 | Bit 0 selects the half-0 hash, bit 1 selects the half-1 hash (0 = plain, 1 = rotated) |
| out_valid | output | 1 | High for one cycle after each captured strobe |
| bucket_lo | output | 12 | Bucket number in table half 0 |
| bucket_hi | output | 12 | Bucket number in table half 1 |

## Verification
The properties assume that `in_valid` and `alg_sel` are never unknown once reset is released, and that `in_valid` is held low for the whole reset. The bench therefore drives every input to a defined value from time zero and keeps the strobe low until reset is released. The check that ties the two halves together assumes that the half span is a power of two, so that the offset appears only in bit 11. The default parameters meet this. Stimulus changes only on falling edges, so every input value is stable across the rising edge that samples it.

// File: rtl/l2hash_pkg.sv
package l2hash_pkg;

  localparam int MAC_W       = 48;
  localparam int VID_W       = 12;
  localparam int SEED_W      = MAC_W + VID_W;
  localparam int SLICE_W     = 11;
  localparam int TBL_ENTRIES = 16384;
  localparam int BKT_WAYS    = 4;
  localparam int N_HALVES    = 2;

  localparam int N_BUCKETS   = TBL_ENTRIES / BKT_WAYS;
  localparam int BKT_W       = $clog2(N_BUCKETS);
  localparam int HALF_SPAN   = N_BUCKETS / N_HALVES;

  typedef enum logic {
    ALG_PLAIN = 1'b0,
    ALG_ROT   = 1'b1
  } alg_e;

  // Left-rotate amount applied to full slice idx in the rotated variant.
  function automatic int slice_rot(input int idx, input bit rot_en);
    int amt;
    amt = 0;
    if (rot_en) begin
      if (idx == 1) amt = 6;
      else if (idx == 3) amt = 5;
    end
    return amt;
  endfunction

endpackage

// File: rtl/l2hash_seed.sv
module l2hash_seed #(
  parameter int MAC_W = 48,
  parameter int VID_W = 12,
  localparam int SEED_W = MAC_W + VID_W
) (
  input  logic [MAC_W-1:0]  mac_i,
  input  logic [VID_W-1:0]  vid_i,
  output logic [SEED_W-1:0] seed_o
);

  // Identifier in the top bits, address below it.
  assign seed_o = {vid_i, mac_i};

endmodule

// File: rtl/l2hash_fold.sv
module l2hash_fold #(
  parameter int SEED_W = 60,
  parameter int SLICE_W = 11,
  parameter bit ROT_EN = 1'b0
) (
  input  logic [SEED_W-1:0]  seed_i,
  output logic [SLICE_W-1:0] hash_o
);

  localparam int N_FULL = SEED_W / SLICE_W;
  localparam int REM_W  = SEED_W - N_FULL * SLICE_W;

  logic [SLICE_W-1:0] term [N_FULL+1];

  for (genvar i = 0; i < N_FULL; i++) begin : g_slice
    localparam int AMT = l2hash_pkg::slice_rot(i, ROT_EN);
    logic [SLICE_W-1:0] slc;
    assign slc = seed_i[i*SLICE_W +: SLICE_W];
    if (AMT == 0) begin : g_straight
      assign term[i] = slc;
    end else begin : g_rotl
      assign term[i] = {slc[SLICE_W-1-AMT:0], slc[SLICE_W-1:SLICE_W-AMT]};
    end
  end

  if (REM_W > 0) begin : g_rem
    assign term[N_FULL] = SLICE_W'(seed_i[SEED_W-1 -: REM_W]);
  end else begin : g_no_rem
    assign term[N_FULL] = '0;
  end

  always_comb begin
    logic [SLICE_W-1:0] acc;
    acc = '0;
    for (int k = 0; k <= N_FULL; k++) begin
      acc = acc ^ term[k];
    end
    hash_o = acc;
  end

endmodule

// File: rtl/l2hash_half.sv
module l2hash_half #(
  parameter int SLICE_W   = 11,
  parameter int BKT_W     = 12,
  parameter int HALF_SPAN = 2048,
  parameter int HALF_IDX  = 0
) (
  input  logic               sel_i,
  input  logic [SLICE_W-1:0] hash_plain_i,
  input  logic [SLICE_W-1:0] hash_rot_i,
  output logic [BKT_W-1:0]   bucket_o
);

  localparam logic [BKT_W-1:0] BASE = BKT_W'(HALF_IDX * HALF_SPAN);

  logic [SLICE_W-1:0] chosen;

  always_comb begin
    unique case (l2hash_pkg::alg_e'(sel_i))
      l2hash_pkg::ALG_ROT: chosen = hash_rot_i;
      default:             chosen = hash_plain_i;
    endcase
    bucket_o = BKT_W'(chosen) + BASE;
  end

endmodule

// File: rtl/l2_bucket_hasher.sv
module l2_bucket_hasher #(
  parameter int MAC_W       = l2hash_pkg::MAC_W,
  parameter int VID_W       = l2hash_pkg::VID_W,
  parameter int SLICE_W     = l2hash_pkg::SLICE_W,
  parameter int TBL_ENTRIES = l2hash_pkg::TBL_ENTRIES,
  parameter int BKT_WAYS    = l2hash_pkg::BKT_WAYS,
  localparam int SEED_W     = MAC_W + VID_W,
  localparam int N_HALVES   = 2,
  localparam int N_BUCKETS  = TBL_ENTRIES / BKT_WAYS,
  localparam int BKT_W      = $clog2(N_BUCKETS),
  localparam int HALF_SPAN  = N_BUCKETS / N_HALVES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [MAC_W-1:0]    mac_addr,
  input  logic [VID_W-1:0]    vlan_id,
  input  logic [N_HALVES-1:0] alg_sel,
  output logic                out_valid,
  output logic [BKT_W-1:0]    bucket_lo,
  output logic [BKT_W-1:0]    bucket_hi
);

  logic [SEED_W-1:0]  seed;
  logic [SLICE_W-1:0] hash_plain;
  logic [SLICE_W-1:0] hash_rot;
  logic [BKT_W-1:0]   bucket_nxt [N_HALVES];

  l2hash_seed #(.MAC_W(MAC_W), .VID_W(VID_W)) u_seed (
    .mac_i  (mac_addr),
    .vid_i  (vlan_id),
    .seed_o (seed)
  );

  // One core per algorithm, shared by both table halves.
  l2hash_fold #(.SEED_W(SEED_W), .SLICE_W(SLICE_W), .ROT_EN(1'b0)) u_fold_plain (
    .seed_i (seed),
    .hash_o (hash_plain)
  );

  l2hash_fold #(.SEED_W(SEED_W), .SLICE_W(SLICE_W), .ROT_EN(1'b1)) u_fold_rot (
    .seed_i (seed),
    .hash_o (hash_rot)
  );

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    l2hash_half #(
      .SLICE_W   (SLICE_W),
      .BKT_W     (BKT_W),
      .HALF_SPAN (HALF_SPAN),
      .HALF_IDX  (h)
    ) u_half (
      .sel_i        (alg_sel[h]),
      .hash_plain_i (hash_plain),
      .hash_rot_i   (hash_rot),
      .bucket_o     (bucket_nxt[h])
    );
  end

  logic             valid_q, valid_d;
  logic [BKT_W-1:0] lo_q, lo_d;
  logic [BKT_W-1:0] hi_q, hi_d;
  logic             cap_en;

  assign cap_en = in_valid;

  always_comb begin
    valid_d = in_valid;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (cap_en) begin
      lo_d = bucket_nxt[0];
      hi_d = bucket_nxt[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      valid_q <= valid_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  assign out_valid = valid_q;
  assign bucket_lo = lo_q;
  assign bucket_hi = hi_q;

endmodule

// File: rtl/l2_bucket_hasher_chk.sv
module l2_bucket_hasher_chk #(
  parameter int BKT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       alg_sel,
  input logic             out_valid,
  input logic [BKT_W-1:0] bucket_lo,
  input logic [BKT_W-1:0] bucket_hi
);

  p_strobe_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bucket_lo) && $stable(bucket_hi)));

  p_lo_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bucket_lo[BKT_W-1]);

  p_hi_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> bucket_hi[BKT_W-1]);

  // Same algorithm on both halves: results differ only by the half offset (R4, R5).
  p_same_alg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (alg_sel[0] == alg_sel[1]))
      |=> (bucket_hi[BKT_W-2:0] == bucket_lo[BKT_W-2:0]));

  always_comb begin
    if (!rst_n) begin
      p_reset_r9: assert (out_valid == 1'b0);
    end
  end

endmodule

bind l2_bucket_hasher l2_bucket_hasher_chk #(.BKT_W(BKT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .alg_sel   (alg_sel),
  .out_valid (out_valid),
  .bucket_lo (bucket_lo),
  .bucket_hi (bucket_hi)
);

// File: tb/l2_bucket_hasher_test.sv
module l2_bucket_hasher_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [47:0] mac_addr;
  logic [11:0] vlan_id;
  logic [1:0]  alg_sel;
  logic        out_valid;
  logic [11:0] bucket_lo;
  logic [11:0] bucket_hi;

  int n_checks;
  int n_fails;
  bit done;

  int exp_valid;
  int exp_lo;
  int exp_hi;

  l2_bucket_hasher uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mac_addr  (mac_addr),
    .vlan_id   (vlan_id),
    .alg_sel   (alg_sel),
    .out_valid (out_valid),
    .bucket_lo (bucket_lo),
    .bucket_hi (bucket_hi)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Bitwise reference: output bit b gathers one seed bit from every chunk.
  function automatic int ref_hash(input logic [59:0] s, input bit rot);
    int r;
    r = 0;
    for (int b = 0; b < 11; b++) begin
      logic x;
      x = s[b] ^ s[22 + b] ^ s[44 + b];
      if (rot) begin
        x = x ^ s[11 + ((b + 5) % 11)] ^ s[33 + ((b + 6) % 11)];
      end else begin
        x = x ^ s[11 + b] ^ s[33 + b];
      end
      if (b < 5) x = x ^ s[55 + b];
      if (x) r = r | (1 << b);
    end
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check("R7 out_valid", int'(out_valid), exp_valid);
    check({tag, " bucket_lo"}, int'(bucket_lo), exp_lo);
    check({tag, " bucket_hi"}, int'(bucket_hi), exp_hi);
    if (out_valid) begin
      check("R6 lo range", int'(bucket_lo < 12'd2048), 1);
      check("R6 hi range", int'(bucket_hi >= 12'd2048), 1);
    end
  endtask

  // Called on a falling edge: check the state, drive new inputs, advance.
  task automatic step(input string tag, input bit v, input logic [47:0] m,
                      input logic [11:0] id, input logic [1:0] sel);
    logic [59:0] s;
    compare(tag);
    in_valid = v;
    mac_addr = m;
    vlan_id  = id;
    alg_sel  = sel;
    s = {id, m};
    exp_valid = v ? 1 : 0;
    if (v) begin
      exp_lo = ref_hash(s, sel[0]);
      exp_hi = 2048 + ref_hash(s, sel[1]);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    mac_addr = 48'h0;
    vlan_id  = 12'h0;
    alg_sel  = 2'b00;
    exp_valid = 0;
    exp_lo    = 0;
    exp_hi    = 0;

    // R9: reset state while the key inputs wiggle
    repeat (2) @(negedge clk);
    mac_addr = 48'hFFFF_FFFF_FFFF;
    vlan_id  = 12'hFFF;
    alg_sel  = 2'b11;
    @(negedge clk);
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 bucket_lo", int'(bucket_lo), 0);
    check("R9 bucket_hi", int'(bucket_hi), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: identifier-only and address-only keys
    for (int i = 0; i < 12; i++) step("R1", 1'b1, 48'h0, 12'(1 << i), 2'b00);
    step("R1", 1'b1, 48'h0, 12'hABC, 2'b11);
    step("R1", 1'b1, 48'h0000_0000_0ABC, 12'h000, 2'b11);

    // R2: single bits walked over the whole seed, plain algorithm
    for (int i = 0; i < 60; i++) begin
      logic [59:0] one;
      one = 60'(1) << i;
      step("R2", 1'b1, one[47:0], one[59:48], 2'b00);
    end

    // R3: the same walk with the rotated algorithm
    for (int i = 0; i < 60; i++) begin
      logic [59:0] one;
      one = 60'(1) << i;
      step("R3", 1'b1, one[47:0], one[59:48], 2'b11);
    end
    step("R3", 1'b1, 48'hFFFF_FFFF_FFFF, 12'hFFF, 2'b11);
    step("R2", 1'b1, 48'hFFFF_FFFF_FFFF, 12'hFFF, 2'b00);

    // R4 and R5: mixed selects per half
    for (int i = 0; i < 24; i++) begin
      logic [59:0] one;
      one = 60'(1) << (11 + i);
      step("R4", 1'b1, one[47:0], one[59:48], 2'b01);
      step("R5", 1'b1, one[47:0], one[59:48], 2'b10);
    end

    // R8: inputs change while the strobe is low
    step("R8", 1'b1, 48'h0123_4567_89AB, 12'h5A5, 2'b01);
    for (int i = 0; i < 8; i++) begin
      step("R8", 1'b0, 48'(i * 48'h1111_2222_3333 + 7), 12'(i * 391), 2'(i));
    end
    step("R8", 1'b1, 48'hDEAD_BEEF_CAFE, 12'h3C3, 2'b10);

    // Mixed traffic with gaps
    for (int i = 0; i < 300; i++) begin
      logic [47:0] m;
      m = {16'($urandom), $urandom};
      step("R5", ($urandom % 4) != 0, m, 12'($urandom), 2'($urandom));
    end

    step("R7", 1'b0, 48'h0, 12'h0, 2'b00);
    compare("R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule